// File: doc/BRIEF.md
# Dual-Tuning-Word Phase Engine with Selectable Phase Offsets

This block is the phase-generation stage of a direct digital synthesizer. It keeps a 32-bit phase accumulator. On every clock the accumulator grows by one of two stored frequency tuning words, and a single select input picks which word. The output frequency is therefore `tuning_word * f_clk / 2^32`. A 2-bit select input picks one of four stored 12-bit phase offsets. That offset is added to the top 12 accumulator bits, which are the output side of the accumulator. The accumulator state itself is never changed by the offset. The registered 12-bit sum, together with a valid strobe, feeds a later sine lookup.

A host loads the six stored words through a 16-bit parallel write port with a 3-bit address and a write strobe. Each tuning word is loaded as two separate 16-bit halves. Each phase offset is loaded in a single write.

Switching between tuning words or between offsets on the select pins does not disturb the accumulator. This allows continuous-phase frequency shift keying and phase shift keying.

Top module: `nco_phase_engine`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, both tuning words and all four offsets to zero. The reset also forces `phase_out` to 0 and `phase_vld` to 0 from the edge after reset is sampled.
- R2: A write to a tuning word uses one of four addresses, each loading one 16-bit half: 0 loads word 0 bits 15..0, 1 loads word 0 bits 31..16, 2 loads word 1 bits 15..0, and 3 loads word 1 bits 31..16.
- R3: A tuning-word write changes only the addressed 16-bit half. The other half of the same word keeps its value.
- R4: Addresses 4, 5, 6 and 7 load offsets 0, 1, 2 and 3 from `wr_data[11:0]`. Bits 15..12 of the data are ignored.
- R5: On every cycle out of reset, the accumulator adds tuning word 0 when `fsel`=0 or tuning word 1 when `fsel`=1. The sum wraps modulo 2^32.
- R6: `psel`=0, 1, 2 or 3 selects offset 0, 1, 2 or 3. The selected offset is added to accumulator bits 31..20 modulo 2^12, and the sum does not feed back into the accumulator.
- R7: `phase_out` is registered. After edge n it shows (accumulator value before edge n)[31:20] plus the offset selected at edge n. `phase_vld` is 1 after every edge that is not in reset.
- R8: A write at edge n is used from edge n+1 onward. Changing `fsel` or `psel` never resets or steps the accumulator beyond its normal add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address (see R2, R4) |
| wr_data | input | 16 | Write data |
| fsel | input | 1 | Tuning word select |
| psel | input | 2 | Phase offset select |
| phase_out | output | 12 | Offset-adjusted phase word |
| phase_vld | output | 1 | Phase word valid |

## Verification
The bench writes the two halves of a tuning word separately. A design that merged or cleared the other half would then drift away from the accumulator model within a few samples. Offsets are written with the upper data nibble set. A design that kept those bits, or that put the offset into the accumulator state, would show wrong or cumulatively shifted phase. The bench also switches `fsel` and `psel` mid-run and sets a tuning word near 2^32 together with offset 0xFFF. Both the 32-bit carry and the 12-bit carry must then be dropped; keeping either one would give wrong samples after the wrap.

// File: rtl/nco_pkg.sv
package nco_pkg;
   localparam int unsigned NCO_WORD_W = 16;
   localparam int unsigned NCO_FTW_W  = 32;
   localparam int unsigned NCO_PH_W   = 12;
   localparam int unsigned NCO_ADDR_W = 3;
   localparam int unsigned NCO_NFTW   = 2;
   localparam int unsigned NCO_NPOFF  = 4;

   function automatic int unsigned sel_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/nco_reg_bank.sv
module nco_reg_bank
   import nco_pkg::*;
#(
   parameter int unsigned WORD_W = NCO_WORD_W,
   parameter int unsigned FTW_W  = NCO_FTW_W,
   parameter int unsigned PH_W   = NCO_PH_W,
   parameter int unsigned ADDR_W = NCO_ADDR_W,
   parameter int unsigned NFTW   = NCO_NFTW,
   parameter int unsigned NPOFF  = NCO_NPOFF,
   localparam int unsigned FS_W  = sel_w(NFTW),
   localparam int unsigned PS_W  = sel_w(NPOFF)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [FS_W-1:0]   fsel,
   input  logic [PS_W-1:0]   psel,
   output logic [FTW_W-1:0]  ftw_sel,
   output logic [PH_W-1:0]   poff_sel
);
   localparam int unsigned HALVES = FTW_W / WORD_W;
   localparam int unsigned SLOTS  = NFTW * HALVES;

   logic [SLOTS-1:0][WORD_W-1:0] ftw_half;
   logic [NFTW-1:0][FTW_W-1:0]   ftw_word;
   logic [NPOFF-1:0][PH_W-1:0]   poff_q;

   generate
      if (FTW_W != HALVES * WORD_W) begin : g_bad_split
         $error("tuning word width must be a multiple of the write width");
      end
      if (PH_W > WORD_W) begin : g_bad_phase
         $error("offset width exceeds write width");
      end
      if (SLOTS + NPOFF > (1 << ADDR_W)) begin : g_bad_addr
         $error("address space too small for register bank");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         ftw_half <= '0;
         poff_q   <= '0;
      end else if (wr_en) begin
         for (int k = 0; k < SLOTS; k++) begin
            if (wr_addr == ADDR_W'(k)) ftw_half[k] <= wr_data;
         end
         for (int j = 0; j < NPOFF; j++) begin
            if (wr_addr == ADDR_W'(SLOTS + j)) poff_q[j] <= wr_data[PH_W-1:0];
         end
      end
   end

   // Halves are stored low-first, so the packed view is already the word array
   assign ftw_word = ftw_half;
   assign ftw_sel  = ftw_word[fsel];
   assign poff_sel = poff_q[psel];

   p_half_keep_r3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == ADDR_W'(0)) |=> ftw_half[1] == $past(ftw_half[1]));

   p_half_load_r2: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == ADDR_W'(1)) |=> ftw_half[1] == $past(wr_data));

   p_phase_low_r4: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == ADDR_W'(SLOTS)) |=> poff_q[0] == $past(wr_data[PH_W-1:0]));
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
   import nco_pkg::*;
#(
   parameter int unsigned FTW_W = NCO_FTW_W,
   parameter int unsigned PH_W  = NCO_PH_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [FTW_W-1:0] ftw_in,
   output logic [PH_W-1:0]  acc_top
);
   logic [FTW_W-1:0] acc;

   generate
      if (PH_W > FTW_W) begin : g_bad_top
         $error("phase output wider than accumulator");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) acc <= '0;
      else     acc <= acc + ftw_in;
   end

   assign acc_top = acc[FTW_W-1 -: PH_W];

   p_acc_step_r5: assert property (@(posedge clk) disable iff (rst)
      !rst |=> acc == $past(acc) + $past(ftw_in));
endmodule

// File: rtl/nco_offset_add.sv
module nco_offset_add
   import nco_pkg::*;
#(
   parameter int unsigned PH_W   = NCO_PH_W,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [PH_W-1:0] acc_top,
   input  logic [PH_W-1:0] poff,
   output logic [PH_W-1:0] phase_out,
   output logic            phase_vld
);
   logic [PH_W-1:0] sum;
   assign sum = acc_top + poff;

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) begin
               phase_out <= '0;
               phase_vld <= 1'b0;
            end else begin
               phase_out <= sum;
               phase_vld <= 1'b1;
            end
         end
      end else begin : g_comb
         assign phase_out = rst ? '0 : sum;
         assign phase_vld = !rst;
      end
   endgenerate
endmodule

// File: rtl/nco_phase_engine.sv
module nco_phase_engine
   import nco_pkg::*;
#(
   parameter int unsigned WORD_W = NCO_WORD_W,
   parameter int unsigned FTW_W  = NCO_FTW_W,
   parameter int unsigned PH_W   = NCO_PH_W,
   parameter int unsigned ADDR_W = NCO_ADDR_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              fsel,
   input  logic [1:0]        psel,
   output logic [PH_W-1:0]   phase_out,
   output logic              phase_vld
);
   logic [FTW_W-1:0] ftw_sel;
   logic [PH_W-1:0]  poff_sel;
   logic [PH_W-1:0]  acc_top;

   nco_reg_bank #(
      .WORD_W(WORD_W), .FTW_W(FTW_W), .PH_W(PH_W), .ADDR_W(ADDR_W),
      .NFTW(2), .NPOFF(4)
   ) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .fsel(fsel), .psel(psel), .ftw_sel(ftw_sel), .poff_sel(poff_sel)
   );

   nco_phase_acc #(.FTW_W(FTW_W), .PH_W(PH_W)) u_acc (
      .clk(clk), .rst(rst), .ftw_in(ftw_sel), .acc_top(acc_top)
   );

   nco_offset_add #(.PH_W(PH_W), .REG_OUT(1'b1)) u_add (
      .clk(clk), .rst(rst), .acc_top(acc_top), .poff(poff_sel),
      .phase_out(phase_out), .phase_vld(phase_vld)
   );

   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (phase_out == '0 && !phase_vld));

   p_vld_run_r7: assert property (@(posedge clk) disable iff (rst)
      !rst |=> phase_vld);
endmodule

// File: tb/sim_nco_phase_engine.sv
module sim_nco_phase_engine;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        fsel = 1'b0;
   logic [1:0]  psel = '0;
   logic [11:0] phase_out;
   logic        phase_vld;

   always #4 clk = ~clk;

   nco_phase_engine u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .fsel(fsel), .psel(psel), .phase_out(phase_out), .phase_vld(phase_vld)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [15:0] m_half [4];
   logic [11:0] m_poff [4];
   logic [31:0] m_acc;

   logic [11:0] q_val [$];
   string       q_tag [$];

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic step(input bit we, input logic [2:0] a, input logic [15:0] d,
                       input bit fs, input logic [1:0] ps, input string tag);
      logic [11:0] e;
      @(negedge clk);
      wr_en = we; wr_addr = a; wr_data = d; fsel = fs; psel = ps;
      e = m_acc[31:20] + m_poff[ps];
      m_acc = m_acc + {m_half[{fs, 1'b1}], m_half[{fs, 1'b0}]};
      if (we) begin
         if (a[2]) m_poff[a[1:0]] = d[11:0];
         else      m_half[a[1:0]] = d;
      end
      @(posedge clk);
      q_val.push_back(e);
      q_tag.push_back(tag);
   endtask

   // monitor: compares one queued sample per cycle
   always @(negedge clk) begin
      if (q_val.size() > 0) begin
         string t;
         logic [11:0] v;
         v = q_val.pop_front();
         t = q_tag.pop_front();
         check(t, {20'd0, phase_out}, {20'd0, v});
         check({t, " valid (R7)"}, {31'd0, phase_vld}, 32'd1);
      end
   end

   task automatic run(input int n, input bit fs, input logic [1:0] ps, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, 3'd0, 16'd0, fs, ps, tag);
   endtask

   initial begin
      for (int i = 0; i < 4; i++) begin m_half[i] = '0; m_poff[i] = '0; end
      m_acc = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset phase", {20'd0, phase_out}, 32'd0);
      check("R1 reset valid", {31'd0, phase_vld}, 32'd0);
      rst = 1'b0;
      run(3, 1'b0, 2'd0, "R1 idle after reset");
      // word 0 by halves
      step(1'b1, 3'd1, 16'h0010, 1'b0, 2'd0, "R2 high half word0");
      step(1'b1, 3'd0, 16'h8000, 1'b0, 2'd0, "R8 write used next edge");
      run(10, 1'b0, 2'd0, "R5 word0 accumulate");
      // word 1 by halves, then switch mid-run
      step(1'b1, 3'd2, 16'hFFFF, 1'b0, 2'd0, "R2 low half word1");
      step(1'b1, 3'd3, 16'h0234, 1'b0, 2'd0, "R2 high half word1");
      run(8, 1'b1, 2'd0, "R8 switch to word1");
      run(4, 1'b0, 2'd0, "R8 switch back word0");
      // only the high half of word 1 changes
      step(1'b1, 3'd3, 16'h0400, 1'b0, 2'd0, "R3 high half rewrite");
      run(6, 1'b1, 2'd0, "R3 low half kept");
      // offsets with upper nibble set
      step(1'b1, 3'd4, 16'hF123, 1'b1, 2'd0, "R4 offset0");
      step(1'b1, 3'd5, 16'hA800, 1'b1, 2'd0, "R4 offset1");
      step(1'b1, 3'd6, 16'h5FFF, 1'b1, 2'd0, "R4 offset2");
      step(1'b1, 3'd7, 16'h0001, 1'b1, 2'd0, "R4 offset3");
      for (int p = 0; p < 4; p++) run(3, 1'b1, 2'(p), "R6 offset select");
      run(4, 1'b0, 2'd3, "R6 offset not accumulated");
      // wraparound of both adders
      step(1'b1, 3'd1, 16'hFFF0, 1'b0, 2'd2, "R5 near-full word0");
      run(12, 1'b0, 2'd2, "R5 acc wrap with R6 offset wrap");
      run(6, 1'b1, 2'd1, "R7 latency alt select");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (200000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule